// File: doc/BRIEF.md
# Parity-Checked Direct-Mapped Word Cache

This block sits between a processor port and a main-memory port and keeps a copy of up to 1024 sixteen-bit words. The processor presents an 18-bit byte address and either reads or writes a single byte or a whole word. Each of the 1024 entries holds a 7-bit tag, the data word, an even-parity bit for each data byte, an even-parity bit for the tag and a valid flag. A line is one word, so a miss fetches exactly one word. A read that finds its word returns it in the same cycle. A read that does not find its word fetches the word from memory and overwrites the entry at that index.

Writes always go to memory. A write that finds its word also updates the cached bytes. A write that does not find its word leaves the cache untouched. Other bus masters report their memory writes on a snoop input, and a snooped word that is cached has its entry invalidated, not updated. After every reset the block walks all entries and clears them, one per cycle, while it reports busy.

A corrupted entry is treated as a miss and refetched. Because corruption cannot happen on its own in logic, a fault-injection input flips one stored bit so that this path can be exercised.

Top module: `pcache_top`

## Requirements
- R1: The byte address splits as tag = bits 17:11, index = bits 10:1, byte select = bit 0 (0 selects data bits 7:0, 1 selects bits 15:8). Every read returns the whole 16-bit word that holds the addressed byte.
- R2: After reset is released, `busy` stays high for exactly 1024 cycles while every entry is cleared. During those cycles `cpu_ready` and `mem_req` stay low, and a pending request is served only once `busy` falls.
- R3: A read that hits raises `cpu_ready` in the first cycle of the request with the stored word, and starts no memory access.
- R4: A read that misses holds `mem_req` high with `mem_we` low and `mem_addr` set to the word address (bit 0 cleared) until `mem_ack`. `cpu_ready` rises in the acknowledge cycle with `mem_rdata`, and the entry at that index takes the new tag and data, replacing any other tag there.
- R5: Every write goes to memory with `mem_we` high. `mem_be` is 01 for a byte at an even address, 10 for a byte at an odd address and 11 for a word. `cpu_ready` rises in the acknowledge cycle.
- R6: A write that hits updates only the enabled byte lanes of the cached word and their parity, so a later read hits and returns the merged word.
- R7: A write that misses does not allocate: a later read of that address misses.
- R8: A snoop pulse (`snoop_valid` with a word address) whose index and tag match a valid entry clears that entry. A snoop with the same index but another tag leaves the entry valid.
- R9: Parity is even. An entry whose tag matches but whose tag parity or either byte parity fails is treated as a read miss and is refilled from memory.
- R10: While `fault_inj` is high in a cycle that writes data into an entry, bit 0 of the stored word is inverted and its parity is not changed to match.
- R11: A second reset invalidates entries that were valid before it, so a previously cached address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_byte | input | 1 | 1 = single byte, 0 = whole word |
| cpu_addr | input | 18 | Byte address |
| cpu_wdata | input | 16 | Write data, byte placed in its own lane |
| cpu_rdata | output | 16 | Read word |
| cpu_ready | output | 1 | Request completes this cycle |
| busy | output | 1 | Clearing sweep in progress |
| fault_inj | input | 1 | Corrupt stored bit 0 on entry writes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 18 | Memory byte address, bit 0 always 0 |
| mem_be | output | 2 | Byte lane enables for writes |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ack | input | 1 | Memory completes the access this cycle |
| snoop_valid | input | 1 | Another master wrote memory |
| snoop_addr | input | 17 | Word address of that write |

## Verification
The hardest case to reach from the ports is a parity failure. Stored parity is always generated from the data it protects, so an entry can only turn bad through `fault_inj`. The stimulus raises `fault_inj` during a fill, reads the same address again, and expects a second memory fetch that returns clean data, followed by a plain hit. Snoops are driven on idle cycles against an entry known to be cached, once with its tag and once with a foreign tag at the same index. Each case is told apart by whether `cpu_ready` comes in the first cycle and by the count of memory reads.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
    localparam int ADDR_W  = 18;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = 2;
    localparam int DATA_W  = BYTE_W * NBYTES;
    localparam int IDX_W   = 10;
    localparam int SEL_W   = 1;
    localparam int TAG_W   = ADDR_W - IDX_W - SEL_W;
    localparam int DEPTH   = 1 << IDX_W;
    localparam int WADDR_W = ADDR_W - SEL_W;

    typedef struct packed {
        logic                    valid;
        logic                    tag_par;
        logic [NBYTES-1:0]       byte_par;
        logic [TAG_W-1:0]        tag;
        logic [DATA_W-1:0]       data;
    } entry_t;

    typedef enum logic [1:0] {OP_NONE, OP_CLEAR, OP_FILL, OP_UPDATE} wop_e;
    typedef enum logic [1:0] {ST_SWEEP, ST_IDLE, ST_FILL, ST_WRITE} state_e;

    function automatic logic even_bit(input logic [BYTE_W-1:0] v);
        return ^v;
    endfunction

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[SEL_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction
endpackage

// File: rtl/pcache_store.sv
module pcache_store
    import pcache_pkg::*;
(
    input  logic              clk,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              rd_hit,
    output logic              wr_hit,
    output logic [DATA_W-1:0] rd_data,
    input  wop_e              op,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic [TAG_W-1:0]  op_tag,
    input  logic [DATA_W-1:0] op_data,
    input  logic [NBYTES-1:0] op_be,
    input  logic              op_inj,
    input  logic              snp_vld,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic [TAG_W-1:0]  snp_tag
);
    entry_t mem [DEPTH];
    entry_t cur, old, nxt, snp_e;
    logic   tag_eq, tag_ok, data_ok, snp_old_hit;

    // lookup path: tag compare plus parity check of tag and both bytes
    always_comb begin
        cur     = mem[lk_idx];
        tag_eq  = cur.valid && (cur.tag == lk_tag);
        tag_ok  = ((^cur.tag) ^ cur.tag_par) == 1'b0;
        data_ok = 1'b1;
        for (int b = 0; b < NBYTES; b++) begin
            if (even_bit(cur.data[b*BYTE_W +: BYTE_W]) != cur.byte_par[b])
                data_ok = 1'b0;
        end
        wr_hit  = tag_eq && tag_ok;
        rd_hit  = wr_hit && data_ok;
        rd_data = cur.data;
    end

    // next value of the entry written by the controller
    always_comb begin
        old = mem[op_idx];
        nxt = old;
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_FILL: begin
                nxt.valid   = 1'b1;
                nxt.tag     = op_tag;
                nxt.tag_par = ^op_tag;
                nxt.data    = op_data;
                for (int b = 0; b < NBYTES; b++)
                    nxt.byte_par[b] = even_bit(op_data[b*BYTE_W +: BYTE_W]);
            end
            OP_UPDATE: begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (op_be[b]) begin
                        nxt.data[b*BYTE_W +: BYTE_W] = op_data[b*BYTE_W +: BYTE_W];
                        nxt.byte_par[b] = even_bit(op_data[b*BYTE_W +: BYTE_W]);
                    end
                end
            end
            default: ;
        endcase
        if (op_inj && (op == OP_FILL || op == OP_UPDATE))
            nxt.data[0] = ~nxt.data[0];
        // a snoop colliding with the written entry judges the new tag
        if (snp_vld && op != OP_NONE && snp_idx == op_idx && nxt.tag == snp_tag)
            nxt.valid = 1'b0;
        snp_e = mem[snp_idx];
        snp_old_hit = snp_vld && (op == OP_NONE || snp_idx != op_idx) &&
                      snp_e.valid && (snp_e.tag == snp_tag);
    end

    always_ff @(posedge clk) begin
        if (op != OP_NONE)
            mem[op_idx] <= nxt;
        if (snp_old_hit)
            mem[snp_idx].valid <= 1'b0;
    end
endmodule

// File: rtl/pcache_ctrl.sv
module pcache_ctrl
    import pcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_byte,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              fault_inj,
    input  logic              rd_hit,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NBYTES-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output wop_e              op,
    output logic [IDX_W-1:0]  op_idx,
    output logic [TAG_W-1:0]  op_tag,
    output logic [DATA_W-1:0] op_data,
    output logic [NBYTES-1:0] op_be,
    output logic              op_inj
);
    state_e            st;
    logic [IDX_W-1:0]  swp;
    logic [NBYTES-1:0] lane;

    always_comb begin
        if (!cpu_byte)        lane = '1;
        else if (cpu_addr[0]) lane = 2'b10;
        else                  lane = 2'b01;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_SWEEP;
            swp <= '0;
        end else begin
            unique case (st)
                ST_SWEEP: begin
                    swp <= swp + 1'b1;
                    if (&swp) st <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (cpu_req) begin
                        if (cpu_we)       st <= ST_WRITE;
                        else if (!rd_hit) st <= ST_FILL;
                    end
                end
                ST_FILL:  if (mem_ack) st <= ST_IDLE;
                ST_WRITE: if (mem_ack) st <= ST_IDLE;
                default:  st <= ST_SWEEP;
            endcase
        end
    end

    always_comb begin
        busy      = (st == ST_SWEEP);
        cpu_ready = 1'b0;
        cpu_rdata = rd_data;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '0;
        mem_addr  = {cpu_addr[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};
        mem_wdata = cpu_wdata;
        op        = OP_NONE;
        op_idx    = busy ? swp : idx_of(cpu_addr);
        op_tag    = tag_of(cpu_addr);
        op_data   = cpu_wdata;
        op_be     = lane;
        op_inj    = fault_inj;
        unique case (st)
            ST_SWEEP: op = OP_CLEAR;
            ST_IDLE:  cpu_ready = cpu_req && !cpu_we && rd_hit;
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    op        = OP_FILL;
                    op_data   = mem_rdata;
                    cpu_ready = 1'b1;
                    cpu_rdata = mem_rdata;
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                mem_be  = lane;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    if (wr_hit) op = OP_UPDATE;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pcache_top.sv
module pcache_top
    import pcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_byte,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              busy,
    input  logic              fault_inj,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NBYTES-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              snoop_valid,
    input  logic [WADDR_W-1:0] snoop_addr
);
    logic              rd_hit, wr_hit, op_inj;
    logic [DATA_W-1:0] rd_data, op_data;
    wop_e              op;
    logic [IDX_W-1:0]  op_idx;
    logic [TAG_W-1:0]  op_tag;
    logic [NBYTES-1:0] op_be;

    pcache_ctrl i_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_byte(cpu_byte), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .fault_inj(fault_inj), .rd_hit(rd_hit), .wr_hit(wr_hit),
        .rd_data(rd_data), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .op(op), .op_idx(op_idx),
        .op_tag(op_tag), .op_data(op_data), .op_be(op_be), .op_inj(op_inj)
    );

    pcache_store i_store (
        .clk(clk), .lk_idx(idx_of(cpu_addr)), .lk_tag(tag_of(cpu_addr)),
        .rd_hit(rd_hit), .wr_hit(wr_hit), .rd_data(rd_data),
        .op(op), .op_idx(op_idx), .op_tag(op_tag), .op_data(op_data),
        .op_be(op_be), .op_inj(op_inj), .snp_vld(snoop_valid),
        .snp_idx(snoop_addr[IDX_W-1:0]), .snp_tag(snoop_addr[WADDR_W-1 -: TAG_W])
    );
endmodule

// File: rtl/pcache_chk.sv
module pcache_chk
    import pcache_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_byte,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NBYTES-1:0] mem_be
);
    localparam logic [IDX_W:0] LAST = (IDX_W+1)'(DEPTH - 1);
    logic [IDX_W:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
    end

    a_r2_busy_quiet: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!cpu_ready && !mem_req));
    a_r2_sweep_end: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt == LAST) |=> !busy);
    a_r2_sweep_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt < LAST) |=> busy);
    a_r3_ready_without_mem: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && !mem_req) |-> (cpu_req && !cpu_we));
    a_r4_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mem_addr[0]);
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && cpu_req) |=> (mem_req && $stable(mem_addr)));
    a_r4_ack_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |-> cpu_ready);
    a_r5_byte_lane: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && cpu_byte) |-> ($countones(mem_be) == 1));
    a_r5_word_lanes: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !cpu_byte) |-> (mem_be == 2'b11));
endmodule

bind pcache_top pcache_chk i_chk (.*);

// File: tb/test_pcache_top.sv
module test_pcache_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_byte = 1'b0;
    logic [17:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready, busy;
    logic        fault_inj = 1'b0;
    logic        mem_req, mem_we;
    logic [17:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [16:0] snoop_addr = '0;

    int n_chk = 0, n_err = 0, fills = 0;
    logic [1:0] be_cap = '0;
    logic [15:0] mm [int];

    typedef struct {logic [15:0] d; string rq;} exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    pcache_top i_pcache_top (.*);

    function automatic logic [15:0] mrd(input int w);
        if (mm.exists(w)) return mm[w];
        return 16'(w * 40503) ^ 16'h5A5A;
    endfunction

    function automatic logic [17:0] mk(input int tag, input int idx, input bit b);
        return {7'(tag), 10'(idx), b};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // memory model: acknowledges after a fixed wait, commits writes at ack
    initial begin
        int wc;
        wc = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wc == 2) begin
                    int w;
                    w = int'(mem_addr[17:1]);
                    mem_ack = 1'b1;
                    be_cap  = mem_be;
                    if (mem_we) begin
                        logic [15:0] v;
                        v = mrd(w);
                        for (int b = 0; b < 2; b++)
                            if (mem_be[b]) v[b*8 +: 8] = mem_wdata[b*8 +: 8];
                        mm[w] = v;
                    end else begin
                        mem_rdata = mrd(w);
                        fills++;
                    end
                    wc = 0;
                end else wc++;
            end else wc = 0;
        end
    end

    // monitor: pops expected read words as the design completes reads
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (cpu_req && !cpu_we && cpu_ready) begin
                if (exp_q.size() == 0) chk(0, "R1 unexpected read completion", 32'(cpu_rdata), 0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cpu_rdata == e.d, e.rq, 32'(cpu_rdata), 32'(e.d));
                end
            end
        end
    end

    task automatic rd(input logic [17:0] a, input bit byt, input bit exp_hit,
                      input string rq, output logic [15:0] got_d);
        int f0, cyc;
        logic got;
        f0 = fills;
        exp_q.push_back('{d: mrd(int'(a[17:1])), rq: {rq, " read data"}});
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_byte = byt; cpu_addr = a;
        cyc = 0;
        do begin
            #4; got = cpu_ready; got_d = cpu_rdata; cyc++;
            if (!got) @(negedge clk);
        end while (!got && cyc < 200);
        @(negedge clk);
        cpu_req = 1'b0;
        if (exp_hit)
            chk(cyc == 1 && fills == f0, {rq, " expected hit"}, 32'(cyc), 1);
        else
            chk(cyc > 1 && fills == f0 + 1, {rq, " expected miss"}, 32'(fills - f0), 1);
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] d, input bit byt,
                      input logic [1:0] exp_be, input string rq);
        int cyc;
        logic got;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_byte = byt; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        do begin
            #4; got = cpu_ready; cyc++;
            if (!got) @(negedge clk);
        end while (!got && cyc < 200);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk(got && cyc > 1 && be_cap == exp_be, {rq, " write lanes"}, 32'(be_cap), 32'(exp_be));
    endtask

    task automatic snoop(input logic [17:0] a, input logic [15:0] nd);
        @(negedge clk);
        mm[int'(a[17:1])] = nd;
        snoop_valid = 1'b1; snoop_addr = a[17:1];
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic do_reset(input logic [17:0] a);
        int n, bad, f0;
        @(negedge clk);
        rst = 1'b1; cpu_req = 1'b0;
        repeat (3) @(negedge clk);
        f0 = fills;
        exp_q.push_back('{d: mrd(int'(a[17:1])), rq: "R2 held read data"});
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_byte = 1'b0; cpu_addr = a;
        rst = 1'b0;
        n = 0; bad = 0;
        #4;
        while (busy && n < 5000) begin
            n++;
            if (cpu_ready || mem_req) bad++;
            #10;
        end
        chk(n == 1024, "R2 sweep length", 32'(n), 1024);
        chk(bad == 0, "R2 quiet during sweep", 32'(bad), 0);
        n = 0;
        while (!cpu_ready && n < 200) begin n++; #10; end
        @(negedge clk);
        cpu_req = 1'b0;
        chk(fills == f0 + 1, "R11 R4 held read misses after sweep", 32'(fills - f0), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [17:0] a_a, a_b, a_c, a_d;
        a_a = mk(5, 100, 1'b0);
        a_b = mk(9, 100, 1'b0);
        a_c = mk(3, 200, 1'b0);
        a_d = mk(1, 300, 1'b0);

        #2;
        chk(busy == 1'b1 && cpu_ready == 1'b0 && mem_req == 1'b0, "R2 reset state", 32'(busy), 1);
        do_reset(a_a);

        rd(a_a, 1'b0, 1'b1, "R3 word read", d);
        rd(a_a | 18'd1, 1'b1, 1'b1, "R1 odd byte read", d);
        chk(d == mrd(int'(a_a[17:1])), "R1 full word on byte read", 32'(d), 32'(mrd(int'(a_a[17:1]))));

        rd(a_b, 1'b0, 1'b0, "R4 same index new tag", d);
        rd(a_a, 1'b0, 1'b0, "R4 replaced entry", d);

        wr(a_a, 16'hBEEF, 1'b0, 2'b11, "R5 word");
        rd(a_a, 1'b0, 1'b1, "R6 word write hit", d);
        chk(d == 16'hBEEF, "R6 word value", 32'(d), 32'hBEEF);
        wr(a_a | 18'd1, 16'h1200, 1'b1, 2'b10, "R5 odd byte");
        wr(a_a, 16'h0034, 1'b1, 2'b01, "R5 even byte");
        rd(a_a, 1'b0, 1'b1, "R6 byte merge", d);
        chk(d == 16'h1234, "R6 merged value", 32'(d), 32'h1234);

        wr(a_c, 16'hCAFE, 1'b0, 2'b11, "R7 miss");
        rd(a_c, 1'b0, 1'b0, "R7 no allocate", d);
        chk(d == 16'hCAFE, "R7 memory took write", 32'(d), 32'hCAFE);

        snoop(mk(6, 100, 1'b0), 16'h0F0F);
        rd(a_a, 1'b0, 1'b1, "R8 foreign tag snoop keeps", d);
        snoop(a_a, 16'h7777);
        rd(a_a, 1'b0, 1'b0, "R8 matching snoop invalidates", d);
        chk(d == 16'h7777, "R8 refetched value", 32'(d), 32'h7777);

        fault_inj = 1'b1;
        rd(a_d, 1'b0, 1'b0, "R10 fill under injection", d);
        fault_inj = 1'b0;
        rd(a_d, 1'b0, 1'b0, "R9 parity failure refills", d);
        rd(a_d, 1'b0, 1'b1, "R9 clean after refill", d);

        do_reset(a_d);
        rd(a_a, 1'b0, 1'b0, "R11 cached before reset", d);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all reads completed", 32'(exp_q.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule